// File: doc/BRIEF.md
# DS3 Framing and Parity Error Injector

This block sits in the transmit path of a serial DS3 M23 framer, directly after frame assembly and before overhead insertion. It receives the assembled frame one bit per valid strobe, together with a start-of-frame marker on the first bit of every frame. It tracks the bit's place in the frame and, on request, inverts chosen overhead bits so that the far end sees framing or parity errors. The frame is 7 subframes. Each subframe is 8 blocks of `BLOCK_BITS` bits, and each block opens with one overhead bit. In every subframe the overhead bits of blocks 1, 3, 5 and 7 are the subframe alignment bits (F-bits). The first overhead bit of subframes 2 and 3 (counting from 0) are the two parity bits (P-bits). The first overhead bits of subframes 4, 5 and 6 are the multiframe alignment bits (M-bits).

There are two error classes, framing and parity, and each has its own enable and its own single-or-continuous choice. Framing errors follow one of four patterns. A request can come from a per-class register strobe or from an asynchronous manual pin, which is synchronised and edge-detected. A select input chooses which of the two sources counts. A request taken in single mode is held in a per-class pending flag until its first opportunity, and that opportunity consumes it. A request that arrives while a multi-error sequence is running is held and starts a new sequence after the running one ends.

Top module: `ds3_err_inject`

## Requirements
- R1: While `rst_n` is low, and after it rises until the first valid bit has passed, `out_valid`, `out_sof` and `out_bit` are 0.
- R2: Every input bit appears on `out_valid`/`out_sof`/`out_bit` exactly one clock later. With both class enables low, the data is unchanged and register strobes have no effect.
- R3: Framing mode 0 (F-bit), single: one request inverts only the first F-bit that follows it.
- R4: Framing mode 2 (subframe error), single: one request inverts all four F-bits (blocks 1, 3, 5, 7) of the next subframe whose block-1 F-bit follows the request.
- R5: Framing mode 1 (M-bit), single: one request inverts the first M-bit (subframe 4) of the next frame that reaches it, and nothing else.
- R6: Framing mode 3 (multiframe error), single: one request inverts the subframe-4 M-bit of two consecutive frames.
- R7: Parity, single: one request inverts both P-bits (subframes 2 and 3) of the next frame that reaches its first P-bit.
- R8: In continuous mode (`fe_cont` or `pe_cont` high), every opportunity of that class is inverted without any request: all F-bits in modes 0 and 2, the subframe-4 M-bit in modes 1 and 3, and both P-bits.
- R9: With `req_src` = 1, only a rising edge on `man_req` requests errors, for both classes at once, and register strobes are ignored. With `req_src` = 0, only `fe_req`/`pe_req` request errors and the pin is ignored.
- R10: A request taken while a multi-error sequence of the same class is running is held. Its sequence starts at the first opportunity after the running one completes.
- R11: Framing and parity requests given in the same cycle are each carried out in full, independently. No bit is inverted by both classes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | A frame bit is present on `in_bit` this cycle |
| in_sof | input | 1 | The present bit is the first bit of a frame |
| in_bit | input | 1 | Frame bit from frame assembly |
| fe_en | input | 1 | Framing error class enable |
| fe_cont | input | 1 | Framing errors at every opportunity |
| fe_mode | input | 2 | Framing pattern: 0 F-bit, 1 M-bit, 2 subframe, 3 multiframe |
| pe_en | input | 1 | Parity error class enable |
| pe_cont | input | 1 | Parity errors in every frame |
| req_src | input | 1 | Request source: 0 register strobes, 1 manual pin |
| fe_req | input | 1 | Register strobe requesting one framing error event |
| pe_req | input | 1 | Register strobe requesting one parity error event |
| man_req | input | 1 | Asynchronous manual request pin, rising edge counts |
| out_valid | output | 1 | Delayed `in_valid` |
| out_sof | output | 1 | Delayed `in_sof` |
| out_bit | output | 1 | Delayed frame bit with errors applied |

## Verification
Two functions can fall in the same cycle. A new request can land while a multiframe sequence is between its two frames. A framing sequence and a parity sequence can also be started by one strobe cycle and run through the same frame. The first case is provoked by strobing the framing request a second time on the first bit of the frame that carries the sequence's second M-bit. The second is provoked by strobing both classes together, or by one manual-pin edge with both classes enabled. Each output bit is judged against an expected mask computed from the frame geometry. Under that mask a held request must add exactly two more M-bit inversions in the two frames that follow, and a frame with both classes active must carry all four F-bit inversions and both P-bit inversions and nothing else.

// File: rtl/ds3_inj_pkg.sv
// Shared definitions for the DS3 error injector: framing pattern codes,
// overhead placement inside the frame and error class indices.
package ds3_inj_pkg;

    // Framing error pattern selected by fe_mode
    typedef enum logic [1:0] {
        FE_FBIT = 2'd0,   // one subframe alignment bit
        FE_MBIT = 2'd1,   // one multiframe alignment bit
        FE_SEF  = 2'd2,   // every alignment bit of one subframe
        FE_OOMF = 2'd3    // one multiframe alignment bit in two frames
    } fe_mode_t;

    // Subframe holding each overhead bit that the injector touches
    localparam int SUB_P1 = 2;
    localparam int SUB_P2 = 3;
    localparam int SUB_M1 = 4;

    // Error class indices
    localparam int CLS_FE = 0;
    localparam int CLS_PE = 1;
    localparam int NCLS   = 2;

    // Multiframe pattern spans this many frames
    localparam int OOMF_FRAMES = 2;
    // Both P-bits are hit per parity event
    localparam int PBIT_COUNT  = 2;

endpackage

// File: rtl/ds3_frame_pos.sv
// Frame position tracker.
// Gives the subframe, block and overhead flag of the bit offered this cycle.
// Assumes a frame of SUBFRAMES x BLOCKS blocks of BLOCK_BITS bits, the overhead
// bit first in each block, and in_sof high on the first bit of every frame.
// Before the first in_sof the count starts from position 0.
module ds3_frame_pos #(
    parameter int SUBFRAMES  = 7,
    parameter int BLOCKS     = 8,
    parameter int BLOCK_BITS = 85
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         in_valid,
    input  logic                         in_sof,
    output logic [$clog2(SUBFRAMES)-1:0] cur_sub,
    output logic [$clog2(BLOCKS)-1:0]    cur_blk,
    output logic                         cur_oh
);
    localparam int SUB_W = $clog2(SUBFRAMES);
    localparam int BLK_W = $clog2(BLOCKS);
    localparam int BIT_W = $clog2(BLOCK_BITS);

    logic [BIT_W-1:0] nxt_bit, cur_bit;
    logic [BLK_W-1:0] nxt_blk;
    logic [SUB_W-1:0] nxt_sub;

    // Position of the present bit: a frame marker forces the origin
    always_comb begin
        cur_bit = in_sof ? '0 : nxt_bit;
        cur_blk = in_sof ? '0 : nxt_blk;
        cur_sub = in_sof ? '0 : nxt_sub;
        cur_oh  = (cur_bit == '0);
    end

    // Advance the expected position by one bit per valid strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nxt_bit <= '0;
            nxt_blk <= '0;
            nxt_sub <= '0;
        end else if (in_valid) begin
            if (cur_bit == BIT_W'(BLOCK_BITS - 1)) begin
                nxt_bit <= '0;
                if (cur_blk == BLK_W'(BLOCKS - 1)) begin
                    nxt_blk <= '0;
                    nxt_sub <= (cur_sub == SUB_W'(SUBFRAMES - 1)) ? '0 : cur_sub + 1'b1;
                end else begin
                    nxt_blk <= cur_blk + 1'b1;
                    nxt_sub <= cur_sub;
                end
            end else begin
                nxt_bit <= cur_bit + 1'b1;
                nxt_blk <= cur_blk;
                nxt_sub <= cur_sub;
            end
        end
    end

endmodule

// File: rtl/ds3_req_src.sv
// Request source selection.
// Synchronises the asynchronous manual pin through SYNC_STAGES flops and
// turns its rising edge into a one-cycle pulse. req_src picks either that
// pulse (for both classes) or the per-class register strobes.
// Assumes register strobes are single-cycle pulses in the clk domain.
module ds3_req_src #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic man_req,
    input  logic req_src,
    input  logic fe_req,
    input  logic pe_req,
    output logic fe_pulse,
    output logic pe_pulse
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    logic                   man_edge;

    // Synchroniser chain and edge history for the manual pin
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], man_req};
            prev_q <= sync_q[SYNC_STAGES-1];
        end
    end

    // Rising edge of the synchronised pin and source multiplexing
    always_comb begin
        man_edge = sync_q[SYNC_STAGES-1] & ~prev_q;
        fe_pulse = req_src ? man_edge : fe_req;
        pe_pulse = req_src ? man_edge : pe_req;
    end

endmodule

// File: rtl/ds3_err_seq.sv
// Error sequencer for one error class.
// A sequence begins at a start opportunity and then takes further bits at
// continuation opportunities until 'total' bits have been inverted. In single
// mode a pending request (which self-clears when consumed) is needed to begin.
// In continuous mode a sequence begins at every start opportunity. Requests
// arriving while a sequence runs stay pending. Disabling the class drops all
// state. Assumes total >= 1 and that start and continuation opportunities are
// qualified with the input valid strobe.
module ds3_err_seq #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             cont,
    input  logic             req,
    input  logic             start_hit,
    input  logic             cont_hit,
    input  logic [CNT_W-1:0] total,
    output logic             flip,
    output logic             busy
);
    logic             pend_q;
    logic             active_q;
    logic [CNT_W-1:0] left_q;
    logic             take;
    logic             start;
    logic             step;

    // Decide whether the present bit is inverted
    always_comb begin
        take  = pend_q | req;
        start = en & ~active_q & start_hit & (cont | take);
        step  = en & active_q & cont_hit;
        flip  = start | step;
        busy  = active_q;
    end

    // Pending request flag and remaining-error count
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            pend_q   <= 1'b0;
            active_q <= 1'b0;
            left_q   <= '0;
        end else begin
            if (cont)
                pend_q <= 1'b0;
            else if (start)
                pend_q <= pend_q & req;
            else
                pend_q <= take;

            if (start) begin
                active_q <= (total > CNT_W'(1));
                left_q   <= total - CNT_W'(1);
            end else if (step) begin
                left_q   <= left_q - CNT_W'(1);
                active_q <= (left_q > CNT_W'(1));
            end
        end
    end

endmodule

// File: rtl/ds3_err_inject.sv
// DS3 framing and parity error injector, top level.
// Tracks the frame position of the incoming serial bits, maps the chosen
// framing pattern and the parity class onto start and continuation
// opportunities, runs one sequencer per class and inverts the selected
// overhead bits. Output is registered: one clock of latency.
// Assumes the M23 overhead layout: F-bits in odd blocks, P-bits in block 0 of
// subframes 2 and 3, M-bits in block 0 of subframes 4 to 6. Configuration is
// held steady while a sequence is running.
module ds3_err_inject
    import ds3_inj_pkg::*;
#(
    parameter int SUBFRAMES   = 7,
    parameter int BLOCKS      = 8,
    parameter int BLOCK_BITS  = 85,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    input  logic       in_sof,
    input  logic       in_bit,
    input  logic       fe_en,
    input  logic       fe_cont,
    input  logic [1:0] fe_mode,
    input  logic       pe_en,
    input  logic       pe_cont,
    input  logic       req_src,
    input  logic       fe_req,
    input  logic       pe_req,
    input  logic       man_req,
    output logic       out_valid,
    output logic       out_sof,
    output logic       out_bit
);
    localparam int SUB_W   = $clog2(SUBFRAMES);
    localparam int BLK_W   = $clog2(BLOCKS);
    localparam int SEF_RUN = BLOCKS / 2;
    localparam int CNT_W   = $clog2(SEF_RUN + 1) + 1;

    logic [SUB_W-1:0] cur_sub;
    logic [BLK_W-1:0] cur_blk;
    logic             cur_oh;
    logic             fe_pulse, pe_pulse;
    logic             hit_f, hit_f1, hit_m1, hit_p1, hit_p2, hit_p;
    logic             fe_start, fe_next;
    logic [CNT_W-1:0] fe_total;

    logic [NCLS-1:0]  cls_en, cls_cont, cls_req, cls_start, cls_next;
    logic [NCLS-1:0]  cls_flip, cls_busy;
    logic [CNT_W-1:0] cls_total [NCLS];

    ds3_frame_pos #(
        .SUBFRAMES  (SUBFRAMES),
        .BLOCKS     (BLOCKS),
        .BLOCK_BITS (BLOCK_BITS)
    ) u_pos (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_sof   (in_sof),
        .cur_sub  (cur_sub),
        .cur_blk  (cur_blk),
        .cur_oh   (cur_oh)
    );

    ds3_req_src #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_req (
        .clk      (clk),
        .rst_n    (rst_n),
        .man_req  (man_req),
        .req_src  (req_src),
        .fe_req   (fe_req),
        .pe_req   (pe_req),
        .fe_pulse (fe_pulse),
        .pe_pulse (pe_pulse)
    );

    // Overhead bit classification of the present valid bit
    always_comb begin
        hit_f  = in_valid & cur_oh & cur_blk[0];
        hit_f1 = in_valid & cur_oh & (cur_blk == BLK_W'(1));
        hit_m1 = in_valid & cur_oh & (cur_blk == '0) & (cur_sub == SUB_W'(SUB_M1));
        hit_p1 = in_valid & cur_oh & (cur_blk == '0) & (cur_sub == SUB_W'(SUB_P1));
        hit_p2 = in_valid & cur_oh & (cur_blk == '0) & (cur_sub == SUB_W'(SUB_P2));
        hit_p  = hit_p1 | hit_p2;
    end

    // Framing pattern to opportunity mapping
    always_comb begin
        unique case (fe_mode_t'(fe_mode))
            FE_FBIT: begin
                fe_start = hit_f;
                fe_next  = 1'b0;
                fe_total = CNT_W'(1);
            end
            FE_MBIT: begin
                fe_start = hit_m1;
                fe_next  = 1'b0;
                fe_total = CNT_W'(1);
            end
            FE_SEF: begin
                fe_start = hit_f1;
                fe_next  = hit_f;
                fe_total = CNT_W'(SEF_RUN);
            end
            default: begin
                fe_start = hit_m1;
                fe_next  = hit_m1;
                fe_total = CNT_W'(OOMF_FRAMES);
            end
        endcase
    end

    // Per-class control vectors feeding the sequencer array
    always_comb begin
        cls_en[CLS_FE]    = fe_en;
        cls_cont[CLS_FE]  = fe_cont;
        cls_req[CLS_FE]   = fe_pulse;
        cls_start[CLS_FE] = fe_start;
        cls_next[CLS_FE]  = fe_next;
        cls_total[CLS_FE] = fe_total;
        cls_en[CLS_PE]    = pe_en;
        cls_cont[CLS_PE]  = pe_cont;
        cls_req[CLS_PE]   = pe_pulse;
        cls_start[CLS_PE] = hit_p1;
        cls_next[CLS_PE]  = hit_p2;
        cls_total[CLS_PE] = CNT_W'(PBIT_COUNT);
    end

    for (genvar c = 0; c < NCLS; c++) begin : g_cls
        ds3_err_seq #(
            .CNT_W (CNT_W)
        ) u_seq (
            .clk       (clk),
            .rst_n     (rst_n),
            .en        (cls_en[c]),
            .cont      (cls_cont[c]),
            .req       (cls_req[c]),
            .start_hit (cls_start[c]),
            .cont_hit  (cls_next[c]),
            .total     (cls_total[c]),
            .flip      (cls_flip[c]),
            .busy      (cls_busy[c])
        );
    end

    // Registered output with the selected bits inverted
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_sof   <= 1'b0;
            out_bit   <= 1'b0;
        end else begin
            out_valid <= in_valid;
            out_sof   <= in_valid & in_sof;
            out_bit   <= in_valid & (in_bit ^ (|cls_flip));
        end
    end

endmodule

// File: rtl/ds3_err_inject_chk.sv
// Assertion checker for ds3_err_inject, attached by bind.
// Relates the registered outputs to the inputs and the two sequencers to the
// position classification that drives them.
module ds3_err_inject_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       in_valid,
    input logic       in_bit,
    input logic       out_valid,
    input logic       out_bit,
    input logic       fe_en,
    input logic       fe_cont,
    input logic [1:0] fe_mode,
    input logic       pe_en,
    input logic [1:0] flip,
    input logic [1:0] busy,
    input logic       hit_f,
    input logic       hit_m1,
    input logic       hit_p
);
    // R2: output valid is the input valid one clock later
    a_r2_valid_delay: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R2: nothing is altered while both classes are disabled
    a_r2_clean_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !fe_en && !pe_en) |=> (out_bit == $past(in_bit)));

    // R11: no bit is inverted by both classes
    a_r11_one_flip: assert property (@(posedge clk) disable iff (!rst_n)
        !(flip[0] && flip[1]));

    // R3: framing inversions only land on alignment bits
    a_r3_fe_on_align: assert property (@(posedge clk) disable iff (!rst_n)
        flip[0] |-> (hit_f || hit_m1));

    // R7: parity inversions only land on P-bits
    a_r7_pe_on_pbit: assert property (@(posedge clk) disable iff (!rst_n)
        flip[1] |-> hit_p);

    // R8: continuous F-bit mode takes every F-bit
    a_r8_cont_every_f: assert property (@(posedge clk) disable iff (!rst_n)
        (fe_en && fe_cont && fe_mode == 2'd0 && hit_f) |-> flip[0]);

    // R10: disabling a class drops its running sequence
    a_r10_drop_on_off: assert property (@(posedge clk) disable iff (!rst_n)
        !pe_en |=> !busy[1]);

endmodule

bind ds3_err_inject ds3_err_inject_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_bit    (in_bit),
    .out_valid (out_valid),
    .out_bit   (out_bit),
    .fe_en     (fe_en),
    .fe_cont   (fe_cont),
    .fe_mode   (fe_mode),
    .pe_en     (pe_en),
    .flip      (cls_flip),
    .busy      (cls_busy),
    .hit_f     (hit_f),
    .hit_m1    (hit_m1),
    .hit_p     (hit_p)
);

// File: tb/tb_ds3_err_inject.sv
// Bench for ds3_err_inject on a shortened frame (5-bit blocks, 280-bit frame).
// Every output bit of every scenario is compared with a mask computed from
// the frame geometry and the requirements.
`timescale 1ns/1ps
module tb_ds3_err_inject;

    localparam int BB     = 5;
    localparam int NBLK   = 8;
    localparam int NSUB   = 7;
    localparam int FRAME  = NSUB * NBLK * BB;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0, in_sof = 1'b0, in_bit = 1'b0;
    logic       fe_en = 1'b0, fe_cont = 1'b0, pe_en = 1'b0, pe_cont = 1'b0;
    logic [1:0] fe_mode = 2'd0;
    logic       req_src = 1'b0, fe_req = 1'b0, pe_req = 1'b0, man_req = 1'b0;
    logic       out_valid, out_sof, out_bit;

    int vectors = 0;
    int fails   = 0;

    // Expected-mask scenario description
    int fm    = 0;   // 0 none, 1 F-bit, 2 M-bit, 3 subframe, 4 multiframe
    bit fc    = 0;
    bit pon   = 0;
    bit pc    = 0;
    bit hold  = 0;

    always #2 clk = ~clk;

    ds3_err_inject #(
        .SUBFRAMES  (NSUB),
        .BLOCKS     (NBLK),
        .BLOCK_BITS (BB)
    ) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
        .in_bit(in_bit), .fe_en(fe_en), .fe_cont(fe_cont), .fe_mode(fe_mode),
        .pe_en(pe_en), .pe_cont(pe_cont), .req_src(req_src), .fe_req(fe_req),
        .pe_req(pe_req), .man_req(man_req), .out_valid(out_valid),
        .out_sof(out_sof), .out_bit(out_bit)
    );

    task automatic check(input string tag, input logic [2:0] act, input logic [2:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: {valid,sof,bit} actual %b expected %b", tag, act, exp);
        end
    endtask

    function automatic bit data_pat(int f, int p);
        return ((p * 37 + f * 11) % 7) < 3;
    endfunction

    // Expected inversion of the bit at subframe s, block b, frame f
    function automatic bit flip_exp(int f, int s, int b);
        bit r = 0;
        bit fb = (b % 2) == 1;
        bit m1 = (s == 4) && (b == 0);
        case (fm)
            1: r = fb && (fc || (f == 0 && s == 0 && b == 1));
            2: r = m1 && (fc || f == 0);
            3: r = fb && (fc || (f == 0 && s == 0));
            4: r = m1 && (fc || f < 2 || (hold && f < 4));
            default: r = 0;
        endcase
        if (pon && (s == 2 || s == 3) && b == 0 && (pc || f == 0)) r = 1;
        return r;
    endfunction

    // Apply a configuration after one idle cycle with both classes off
    task automatic cfg(input bit fen, input bit fco, input logic [1:0] mode,
                       input bit pen, input bit pco, input bit src);
        @(negedge clk);
        fe_en = 0; pe_en = 0; fe_cont = 0; pe_cont = 0;
        @(negedge clk);
        fe_en = fen; fe_cont = fco; fe_mode = mode;
        pe_en = pen; pe_cont = pco; req_src = src;
    endtask

    // Stream nf frames, give requests at frame 0 bit 0, check every bit
    task automatic run_frames(input int nf, input bit fe_s, input bit pe_s,
                              input bit pin, input bit hold_s, input string tag);
        for (int f = 0; f < nf; f++) begin
            for (int p = 0; p < FRAME; p++) begin
                int  s   = p / (NBLK * BB);
                int  b   = (p / BB) % NBLK;
                bit  oh  = (p % BB) == 0;
                bit  d   = data_pat(f, p);
                bit  x   = oh && flip_exp(f, s, b);
                @(negedge clk);
                in_valid = 1; in_sof = (p == 0); in_bit = d;
                fe_req = (p == 0) && ((f == 0 && fe_s) || (f == 1 && hold_s));
                pe_req = (p == 0) && (f == 0) && pe_s;
                if (p == 0 && f == 0 && pin) man_req = 1;
                if (p == 0 && f == 1) man_req = 0;
                @(posedge clk);
                #1;
                check(tag, {out_valid, out_sof, out_bit}, {1'b1, (p == 0), d ^ x});
            end
        end
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            in_valid = 0; in_sof = 0; in_bit = 0; fe_req = 0; pe_req = 0; man_req = 0;
            @(posedge clk);
            #1;
            check("R2 idle", {out_valid, out_sof, out_bit}, 3'b000);
        end
    endtask

    task automatic set_exp(input int m, input bit c, input bit p, input bit pco, input bit h);
        fm = m; fc = c; pon = p; pc = pco; hold = h;
    endtask

    initial begin
        // R1: reset holds outputs low even with a valid bit offered
        in_valid = 1; in_bit = 1; in_sof = 1;
        for (int i = 0; i < 4; i++) begin
            @(posedge clk);
            #1;
            check("R1 in reset", {out_valid, out_sof, out_bit}, 3'b000);
        end
        @(negedge clk);
        in_valid = 0; in_bit = 0; in_sof = 0;
        rst_n = 1;
        @(posedge clk);
        #1;
        check("R1 after reset", {out_valid, out_sof, out_bit}, 3'b000);

        // R2: classes off, strobes ignored, data passes with one clock delay
        cfg(0, 0, 2'd0, 0, 0, 0);
        set_exp(0, 0, 0, 0, 0);
        run_frames(2, 1, 1, 0, 0, "R2 passthrough");

        // R3: single F-bit error
        cfg(1, 0, 2'd0, 0, 0, 0);
        set_exp(1, 0, 0, 0, 0);
        run_frames(2, 1, 0, 0, 0, "R3 F-bit single");

        // R4: single subframe error
        cfg(1, 0, 2'd2, 0, 0, 0);
        set_exp(3, 0, 0, 0, 0);
        run_frames(2, 1, 0, 0, 0, "R4 subframe single");

        // R5: single M-bit error
        cfg(1, 0, 2'd1, 0, 0, 0);
        set_exp(2, 0, 0, 0, 0);
        run_frames(2, 1, 0, 0, 0, "R5 M-bit single");

        // R6: multiframe error over two frames
        cfg(1, 0, 2'd3, 0, 0, 0);
        set_exp(4, 0, 0, 0, 0);
        run_frames(3, 1, 0, 0, 0, "R6 multiframe single");

        // R7: parity error on both P-bits
        cfg(0, 0, 2'd0, 1, 0, 0);
        set_exp(0, 0, 1, 0, 0);
        run_frames(2, 0, 1, 0, 0, "R7 parity single");

        // R8: continuous F-bit with continuous parity
        cfg(1, 1, 2'd0, 1, 1, 0);
        set_exp(1, 1, 1, 1, 0);
        run_frames(2, 0, 0, 0, 0, "R8 continuous F and P");

        // R8: continuous subframe pattern covers every F-bit
        cfg(1, 1, 2'd2, 0, 0, 0);
        set_exp(3, 1, 0, 0, 0);
        run_frames(2, 0, 0, 0, 0, "R8 continuous subframe");

        // R8: continuous M-bit pattern
        cfg(1, 1, 2'd1, 0, 0, 0);
        set_exp(2, 1, 0, 0, 0);
        run_frames(2, 0, 0, 0, 0, "R8 continuous M-bit");

        // R9: pin source selected, register strobes ignored
        cfg(1, 0, 2'd2, 1, 0, 1);
        set_exp(0, 0, 0, 0, 0);
        run_frames(2, 1, 1, 0, 0, "R9 strobe ignored");

        // R9: pin source selected, one pin edge requests both classes
        cfg(1, 0, 2'd2, 1, 0, 1);
        set_exp(3, 0, 1, 0, 0);
        run_frames(2, 0, 0, 1, 0, "R9 pin request");

        // R9: register source selected, pin ignored
        cfg(1, 0, 2'd2, 1, 0, 0);
        set_exp(0, 0, 0, 0, 0);
        run_frames(2, 0, 0, 1, 0, "R9 pin ignored");

        // R10: second multiframe request during the first sequence is held
        cfg(1, 0, 2'd3, 0, 0, 0);
        set_exp(4, 0, 0, 0, 1);
        run_frames(5, 1, 0, 0, 1, "R10 held request");

        // R11: framing and parity strobed in the same cycle
        cfg(1, 0, 2'd2, 1, 0, 0);
        set_exp(3, 0, 1, 0, 0);
        run_frames(2, 1, 1, 0, 0, "R11 both classes");

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    // Watchdog: a hung run is reported as a failure
    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule